// File: doc/BRIEF.md
# Joypad-Line Serial Packet Receiver

This block rebuilds fixed-length command packets that software sends one bit at a time by writing a 2-bit value to the two joypad select lines. Each write presents a symbol. Driving both lines low starts a packet. Pulling only one line low carries a one or a zero. Releasing both lines is a neutral gap between symbols. A write that repeats the previous value carries no information, so the sender has to put a gap between two equal bits.

The receiver counts the bits and places them LSB first into a 16-byte buffer. After the last data bit it waits for a stop symbol. When the stop symbol arrives it raises a one-cycle valid pulse. The whole packet sits on a flat output bus, and the bus keeps its contents until the next start symbol. Decoding the command inside the packet is left to the consumer.

Top module: `jp_packet_rx`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `pkt_data` is all zero and `pkt_valid` is low. The remembered previous value is 3, so a first write of 1 after reset records a one at bit 0.
- R2: A write of value 0 (both lines low) sets the bit counter to 0 and clears all of `pkt_data` by the next cycle. This happens whether or not the previous write was also 0.
- R3: A write of 1 or 2 that equals the previously written value changes neither the buffer nor the counter.
- R4: A changed write of 1 while the counter is below 128 sets bit (counter mod 8) of byte (counter / 8) and then increments the counter. Byte k sits on `pkt_data[8k+7:8k]`.
- R5: A changed write of 2 while the counter is below 128 increments the counter and leaves the buffer alone, so it records a zero.
- R6: A changed write of 2 while the counter equals 128 is the stop symbol. `pkt_valid` is high for exactly the one cycle after that write, with the assembled packet on `pkt_data`, and the counter moves past 128.
- R7: While the counter is 128 or more, writes of 1 and 2 do not change the buffer. After a delivery, no further stop symbol produces a second pulse until a write of 0 restarts the packet.
- R8: A write of 3 (both lines released) never changes the counter or the buffer.
- R9: After a delivery, `pkt_data` keeps the delivered packet until the next write of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_we | input | 1 | Strobe that marks a write of the select value |
| sel_val | input | 2 | Select line value written (0 start, 1 one, 2 zero, 3 gap) |
| pkt_data | output | 8*PKT_BYTES | Packet buffer, byte k on bits [8k+7:8k] |
| pkt_valid | output | 1 | One-cycle pulse when a packet completes |

## Verification
A wrong bit counter shows up in two places. The bit set by the next one-symbol lands at the wrong buffer position, visible on `pkt_data` one cycle after the write. The stop pulse either never comes or arrives after the wrong number of symbols. A previous-value register that fails to suppress repeats shows as extra bits or a shifted packet within one write. A counter that does not stop at 128 shows as a changed buffer or a second valid pulse after the stop symbol. The bench drives whole packets and compares each delivered packet against a scoreboard. It also probes single writes and reads the buffer back one cycle later.

// File: rtl/jp_pkt_pkg.sv
package jp_pkt_pkg;

  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_ONE   = 2'd1,
    SYM_ZERO  = 2'd2,
    SYM_GAP   = 2'd3
  } jp_sym_e;

  typedef struct packed {
    logic clr;
    logic one;
    logic zero;
    logic deliver;
  } jp_ev_t;

endpackage

// File: rtl/jp_sym_decode.sv
module jp_sym_decode
  import jp_pkt_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [1:0]       sel_val,
  input  logic [CNT_W-1:0] cnt,
  output logic [1:0]       prev_val,
  output jp_ev_t           ev
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PKT_BITS);

  logic [1:0] prev_q;
  logic       changed;
  logic       room;

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_q <= 2'b11;
    else if (sel_we) prev_q <= sel_val;
  end

  assign prev_val   = prev_q;
  assign changed    = sel_we && (sel_val != prev_q);
  assign room       = cnt < CNT_FULL;
  assign ev.clr     = sel_we && (sel_val == SYM_START);
  assign ev.one     = changed && (sel_val == SYM_ONE) && room;
  assign ev.zero    = changed && (sel_val == SYM_ZERO) && room;
  assign ev.deliver = changed && (sel_val == SYM_ZERO) && (cnt == CNT_FULL);

  // R3: a repeated write of the same value leaves the register unchanged
  assert_prev_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val == prev_q) |=> $stable(prev_q));

endmodule

// File: rtl/jp_bit_counter.sv
module jp_bit_counter
  import jp_pkt_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  jp_ev_t           ev,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(PKT_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign step = ev.one || ev.zero || ev.deliver;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ev.clr) cnt_q <= '0;
    else if (step)   cnt_q <= next_count(cnt_q);
  end

  assign cnt = cnt_q;

  // R7: counting stops once the stop symbol has been taken
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_DONE);

endmodule

// File: rtl/jp_pkt_buffer.sv
module jp_pkt_buffer
  import jp_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 16,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  jp_ev_t                 ev,
  input  logic [CNT_W-1:0]       cnt,
  output logic [8*PKT_BYTES-1:0] data
);
  localparam int BYTE_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;

  function automatic logic [BYTE_W-1:0] byte_of(input logic [CNT_W-1:0] c);
    return BYTE_W'(c >> 3);
  endfunction

  function automatic logic [2:0] bit_of(input logic [CNT_W-1:0] c);
    return c[2:0];
  endfunction

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;

    assign hit = ev.one && (byte_of(cnt) == BYTE_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)      byte_q <= '0;
      else if (ev.clr) byte_q <= '0;
      else if (hit)    byte_q[bit_of(cnt)] <= 1'b1;
    end

    assign data[8*g +: 8] = byte_q;
  end

  // R5: without a one-symbol or a start symbol the buffer holds
  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev.clr && !ev.one) |=> $stable(data));

endmodule

// File: rtl/jp_packet_rx.sv
module jp_packet_rx
  import jp_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_we,
  input  logic [1:0]             sel_val,
  output logic [8*PKT_BYTES-1:0] pkt_data,
  output logic                   pkt_valid
);
  localparam int PKT_BITS = 8 * PKT_BYTES;
  localparam int CNT_W    = $clog2(PKT_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PKT_BITS);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(PKT_BITS + 1);

  jp_ev_t           ev;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       prev_val;
  logic             valid_q;

  jp_sym_decode #(.PKT_BITS(PKT_BITS), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_val(sel_val),
    .cnt(cnt), .prev_val(prev_val), .ev(ev)
  );

  jp_bit_counter #(.PKT_BITS(PKT_BITS), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
  );

  jp_pkt_buffer #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_buffer (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt), .data(pkt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= ev.deliver;
  end

  assign pkt_valid = valid_q;

  // R2: start symbol empties the packet and restarts the count
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val == 2'd0) |=> (pkt_data == '0 && cnt == '0 && !pkt_valid));

  // R3: a repeated data value is ignored
  assert_repeat_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val != 2'd0 && sel_val == prev_val) |=> ($stable(pkt_data) && $stable(cnt)));

  // R4: a fresh one-symbol advances the count by one
  assert_one_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val == 2'd1 && prev_val != 2'd1 && cnt < CNT_FULL)
      |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R6: the valid pulse lasts one cycle and only follows the stop symbol
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  assert_valid_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (cnt == CNT_DONE));

  // R7: a full buffer ignores further one-symbols
  assert_full_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val == 2'd1 && cnt >= CNT_FULL) |=> $stable(pkt_data));

  // R8: the gap symbol never touches count or buffer
  assert_gap_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_val == 2'd3) |=> ($stable(pkt_data) && $stable(cnt)));

endmodule

// File: tb/jp_packet_rx_tb.sv
module jp_packet_rx_tb;
  localparam int NB = 16;
  localparam int NBITS = 8 * NB;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sel_we = 1'b0;
  logic [1:0]       sel_val = 2'd3;
  logic [NBITS-1:0] pkt_data;
  logic             pkt_valid;

  int checks = 0;
  int fails = 0;
  int delivered = 0;
  int expected_deliveries = 0;
  bit done = 1'b0;
  logic prev_valid = 1'b0;
  logic [NBITS-1:0] exp_q[$];

  always #5 clk = ~clk;

  jp_packet_rx #(.PKT_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_val(sel_val),
    .pkt_data(pkt_data), .pkt_valid(pkt_valid)
  );

  task automatic chk(input string req, input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] v);
    @(negedge clk);
    sel_we = 1'b1;
    sel_val = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  // position of packet bit i: byte i/8, bit i%8
  function automatic int pos(input int i);
    return 8 * (i / 8) + (i % 8);
  endfunction

  function automatic logic [NBITS-1:0] make_pkt(input int seed);
    logic [NBITS-1:0] p;
    for (int k = 0; k < NB; k++) p[8*k +: 8] = 8'((k * 37 + seed) & 255);
    return p;
  endfunction

  // driver: push the expected packet, then send it symbol by symbol
  task automatic send_pkt(input logic [NBITS-1:0] p, input bit extra_one);
    wr(2'd0);
    for (int i = 0; i < NBITS; i++) begin
      wr(p[pos(i)] ? 2'd1 : 2'd2);
      wr(2'd3);
    end
    if (extra_one) begin
      wr(2'd1);
      chk("R7 one-symbol after 128 bits", pkt_data, p);
      wr(2'd3);
    end
    exp_q.push_back(p);
    expected_deliveries++;
    wr(2'd2);
    wr(2'd3);
  endtask

  // monitor: scoreboard compare on every valid pulse
  always @(negedge clk) begin
    if (pkt_valid) begin
      delivered++;
      checks++;
      if (prev_valid) begin
        fails++;
        $display("FAIL R6 valid high two cycles actual=1 expected=0");
      end else if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected delivery actual=%h expected=none", pkt_data);
      end else begin
        logic [NBITS-1:0] e;
        e = exp_q.pop_front();
        if (pkt_data !== e) begin
          fails++;
          $display("FAIL R6 packet actual=%h expected=%h", pkt_data, e);
        end
      end
    end
    prev_valid = pkt_valid;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NBITS-1:0] pa;
    logic [NBITS-1:0] po;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset data", pkt_data, '0);
    chk("R1 reset valid", {{(NBITS-1){1'b0}}, pkt_valid}, '0);

    // R1: previous value starts at 3, so a first write of 1 counts
    wr(2'd1);
    chk("R1 first one after reset", pkt_data, NBITS'(1));

    // R2: start symbol clears
    wr(2'd0);
    chk("R2 start clears", pkt_data, '0);
    wr(2'd0);
    chk("R2 repeated start", pkt_data, '0);

    // R3: repeated values ignored
    wr(2'd1); wr(2'd1); wr(2'd1);
    chk("R3 repeated ones", pkt_data, NBITS'(1));
    wr(2'd2); wr(2'd2);
    wr(2'd3);
    wr(2'd1);
    chk("R3 repeated zeros count once", pkt_data, NBITS'(5));

    // R8: gap does not move counter
    wr(2'd3);
    chk("R8 gap keeps data", pkt_data, NBITS'(5));
    wr(2'd3);
    wr(2'd1);
    chk("R8 gap keeps counter", pkt_data, NBITS'(13));

    // R2: mid-packet restart
    wr(2'd0);
    chk("R2 mid-packet clear", pkt_data, '0);
    wr(2'd1);
    chk("R2 counter back at zero", pkt_data, NBITS'(1));

    // R4 R5 R6: full packets
    pa = make_pkt(11);
    send_pkt(pa, 1'b0);
    chk("R9 held after delivery", pkt_data, pa);

    // R7 R9: further symbols after delivery do nothing
    wr(2'd1); wr(2'd3); wr(2'd2); wr(2'd3); wr(2'd2);
    chk("R7 ignored after delivery", pkt_data, pa);
    chk("R9 still held", pkt_data, pa);

    po = '1;
    send_pkt(po, 1'b0);
    chk("R4 all ones", pkt_data, po);

    send_pkt('0, 1'b0);
    chk("R5 all zeros", pkt_data, '0);

    pa = make_pkt(200);
    send_pkt(pa, 1'b1);
    chk("R7 packet with extra symbol", pkt_data, pa);

    // R1: synchronous reset mid-packet
    wr(2'd0); wr(2'd1); wr(2'd3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-packet", pkt_data, '0);

    repeat (4) @(negedge clk);
    chk("R6 delivery count", NBITS'(delivered), NBITS'(expected_deliveries));
    chk("R6 scoreboard drained", NBITS'(exp_q.size()), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule